// File: doc/BRIEF.md
# Time-Multiplexed Long FIR Filter

This block computes a long finite-impulse-response filter. It does not build one multiplier per tap. A few multiply-accumulate lanes work through the taps over many clock cycles, in the long gap between input samples. Every tap is weighted by a run-time coefficient, and the weighted taps are summed into one full-precision dot product. A fixed 16-bit window of that sum is presented as the result, together with a one-cycle valid pulse.

Samples come from a slower producer as level changes on a toggle line. The toggle line is already synchronous to the block clock. The raw input word is 18 bits wide, and the block keeps a 16-bit signed field from it.

The sample history sits in a circular memory that is split into one bank per lane, so no sample is ever moved. The coefficients sit in a second banked memory, which has a write port of its own. With the default of 2048 taps and 4 lanes, a result is ready 515 cycles after a sample is accepted. This fits inside a sample interval of 1000 cycles.

Top module: `fir_tm_engine`

## Requirements
- R1: While reset is held, and for exactly TAPS/LANES cycles after reset is released, `busy` is high. During that time every history slot and every coefficient is set to zero. During reset `out_valid`, `out_data` and `overrun` are 0.
- R2: Any level change on `smp_tog` (rising or falling), seen while `busy` is low, is one new sample. The sample value is `smp_raw[17:2]`, read as a signed 16-bit number.
- R3: The history position numbers work as follows. The newest accepted sample is history position 0. Each newly accepted sample moves every older one up by one position. Positions that have never been filled hold zero.
- R4: `out_data` equals bits [35:20] of the sum, over all taps k, of coefficient[k] × history[k], computed with signed arithmetic.
- R5: `out_valid` is a single-cycle pulse. It is high exactly TAPS/LANES+4 cycles after the cycle in which the sample was presented, which is TAPS/LANES+3 clock edges after the accepting edge. `busy` is high from the edge after acceptance until the pulse, and low while the pulse is high.
- R6: `out_data` changes only at a valid pulse and holds its value between pulses.
- R7: A sample event that arrives while `busy` is high is dropped: the history does not change and no extra result is produced. The event sets `overrun`, which stays high until reset.
- R8: A coefficient write (`cw_en`, with tap index `cw_addr` and signed value `cw_data`) made while `busy` is low takes effect for the next accepted sample.
- R9: A coefficient write made while `busy` is high is held back. It does not change the result being computed, and it takes effect for the next sample. If several writes arrive during one busy window, only the last one is kept.
- R10: Results stay correct after more than TAPS samples have been accepted. Once the circular history wraps, the oldest samples leave the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tog | input | 1 | Sample event line; each level change marks a new sample |
| smp_raw | input | IN_W (18) | Raw input word; the signed sample is bits [17:2] |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | log2(TAPS) | Tap index to write |
| cw_data | input | COEF_W (16) | Signed coefficient value |
| out_data | output | OUT_W (16) | Scaled filter result |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| busy | output | 1 | High while memories are being cleared or a result is being computed |
| overrun | output | 1 | Sticky flag: a sample arrived while busy |

## Verification
There are three kinds of internal fault. A wrong history pointer or bank rotation pairs coefficients with the wrong samples. A lost accumulator term drops a product from the sum. Both faults show at the very next valid pulse, as a wrong `out_data` for any coefficient set that is not symmetric. A control-counter fault moves the valid pulse away from its fixed position, TAPS/LANES+4 cycles after the sample is presented, so the bench catches it on the first sample. A fault in the held coefficient write, or in the handling of an overrun event, shows one sample later, in the result after the one being computed. A wrap fault in the circular history shows only after more than TAPS samples have been accepted, so the bench runs past that point.

// File: rtl/fir_tm_pkg.sv
package fir_tm_pkg;

  // Control phases of the engine.
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,  // zero both memories after reset
    ST_IDLE  = 3'd1,  // wait for a sample event
    ST_RUN   = 3'd2,  // issue one row of reads per cycle
    ST_DRAIN = 3'd3,  // let the read/multiply/add pipe empty
    ST_FIN   = 3'd4   // combine lanes and register the result
  } fir_state_e;

  // Read, product and accumulate registers between the last issue and the combine step.
  localparam int PIPE_DRAIN = 2;

endpackage

// File: rtl/fir_tm_ram.sv
module fir_tm_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  // One write port and one registered read port per bank.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/fir_tm_lane.sv
module fir_tm_lane #(
  parameter int SAMP_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  localparam int PW    = SAMP_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hv,
  input  logic [SAMP_W-1:0] h,
  input  logic [COEF_W-1:0] c,
  output logic [ACC_W-1:0]  acc
);

  logic signed [PW-1:0] prod;
  logic                 pv;

  // Sign-extend one product to the accumulator width.
  function automatic logic [ACC_W-1:0] widen(input logic [PW-1:0] p);
    return {{(ACC_W-PW){p[PW-1]}}, p};
  endfunction

  // Stage 1: register the product. Stage 2: add it into the lane sum.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod <= '0;
      pv   <= 1'b0;
      acc  <= '0;
    end else begin
      pv <= hv;
      if (hv) prod <= $signed(h) * $signed(c);
      if (clr)     acc <= '0;
      else if (pv) acc <= acc + widen(prod);
    end
  end

endmodule

// File: rtl/fir_tm_ctrl.sv
module fir_tm_ctrl
  import fir_tm_pkg::*;
#(
  parameter int NSTEP   = 512,
  localparam int ROW_AW = $clog2(NSTEP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  output logic              busy,
  output logic              clearing,
  output logic              accept,
  output logic              rd_v,
  output logic              fin,
  output logic [ROW_AW-1:0] step
);

  fir_state_e st;
  logic [1:0] dcnt;
  logic       last_row;

  assign last_row = (step == ROW_AW'(NSTEP - 1));
  assign busy     = (st != ST_IDLE);
  assign clearing = (st == ST_CLEAR);
  assign accept   = evt && (st == ST_IDLE);
  assign fin      = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_CLEAR;
      step <= '0;
      dcnt <= '0;
      rd_v <= 1'b0;
    end else begin
      rd_v <= (st == ST_RUN);
      case (st)
        ST_CLEAR: begin
          step <= step + 1'b1;
          if (last_row) begin
            st   <= ST_IDLE;
            step <= '0;
          end
        end
        ST_IDLE: begin
          if (evt) begin
            st   <= ST_RUN;
            step <= '0;
          end
        end
        ST_RUN: begin
          step <= step + 1'b1;
          if (last_row) begin
            st   <= ST_DRAIN;
            step <= '0;
            dcnt <= '0;
          end
        end
        ST_DRAIN: begin
          dcnt <= dcnt + 1'b1;
          if (dcnt == 2'(PIPE_DRAIN - 1)) st <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fir_tm_engine.sv
module fir_tm_engine
  import fir_tm_pkg::*;
#(
  parameter int TAPS     = 2048,
  parameter int LANES    = 4,
  parameter int IN_W     = 18,
  parameter int SAMP_LSB = 2,
  parameter int SAMP_W   = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 40,
  parameter int OUT_W    = 16,
  parameter int OUT_LSB  = 20,
  localparam int TAP_AW  = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tog,
  input  logic [IN_W-1:0]   smp_raw,
  input  logic              cw_en,
  input  logic [TAP_AW-1:0] cw_addr,
  input  logic [COEF_W-1:0] cw_data,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_valid,
  output logic              busy,
  output logic              overrun
);

  localparam int LB     = $clog2(LANES);
  localparam int NSTEP  = TAPS / LANES;
  localparam int ROW_AW = $clog2(NSTEP);
  localparam int SUM_W  = ACC_W + LB;

  // ---------------- arithmetic helpers ----------------
  function automatic logic [SAMP_W-1:0] pick_sample(input logic [IN_W-1:0] raw);
    return raw[SAMP_LSB +: SAMP_W];
  endfunction

  // History bank b holds address a where a mod LANES == b. For newest pointer p,
  // the tap offset that bank b serves in every row is (p - b) mod LANES.
  function automatic logic [LB-1:0] lane_of_bank(input logic [TAP_AW-1:0] p, input int b);
    return LB'(p[LB-1:0] - LB'(b));
  endfunction

  // Row of bank b that holds tap lane_of_bank(p,b) at step 0.
  function automatic logic [ROW_AW-1:0] base_row(input logic [TAP_AW-1:0] p, input int b);
    logic [TAP_AW-1:0] a;
    a = p - TAP_AW'(lane_of_bank(p, b));
    return a[TAP_AW-1 -: ROW_AW];
  endfunction

  function automatic logic [OUT_W-1:0] scale_out(input logic [SUM_W-1:0] s);
    return s[OUT_LSB +: OUT_W];
  endfunction

  function automatic logic [SUM_W-1:0] widen_acc(input logic [ACC_W-1:0] a);
    return {{LB{a[ACC_W-1]}}, a};
  endfunction

  // ---------------- sample event ----------------
  logic tog_q;
  logic smp_evt;
  assign smp_evt = smp_tog ^ tog_q;

  logic              clearing, accept, rd_v, fin;
  logic [ROW_AW-1:0] step;

  fir_tm_ctrl #(.NSTEP(NSTEP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (smp_evt),
    .busy     (busy),
    .clearing (clearing),
    .accept   (accept),
    .rd_v     (rd_v),
    .fin      (fin),
    .step     (step)
  );

  // Newest-sample pointer into the circular history.
  logic [TAP_AW-1:0] wr_ptr, nxt_ptr;
  assign nxt_ptr = wr_ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q  <= smp_tog;
      wr_ptr <= '0;
    end else begin
      tog_q <= smp_tog;
      if (accept) wr_ptr <= nxt_ptr;
    end
  end

  // ---------------- coefficient write path with one held slot ----------------
  logic              hold_v;
  logic [TAP_AW-1:0] hold_addr;
  logic [COEF_W-1:0] hold_data;
  logic              commit_en;
  logic [TAP_AW-1:0] com_addr;
  logic [COEF_W-1:0] com_data;

  assign commit_en = !busy && (hold_v || cw_en);
  assign com_addr  = hold_v ? hold_addr : cw_addr;
  assign com_data  = hold_v ? hold_data : cw_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (cw_en && (busy || hold_v)) begin
      hold_v    <= 1'b1;
      hold_addr <= cw_addr;
      hold_data <= cw_data;
    end else if (!busy) begin
      hold_v <= 1'b0;
    end
  end

  // ---------------- banked memories and MAC lanes ----------------
  logic [SAMP_W-1:0] hist_q [LANES];
  logic [COEF_W-1:0] coef_q [LANES];
  logic [ACC_W-1:0]  acc    [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic              h_we, c_we;
    logic [ROW_AW-1:0] h_wa, h_ra, c_wa;
    logic [SAMP_W-1:0] h_wd;
    logic [COEF_W-1:0] c_wd;

    assign h_we = clearing || (accept && (nxt_ptr[LB-1:0] == LB'(b)));
    assign h_wa = clearing ? step : nxt_ptr[TAP_AW-1 -: ROW_AW];
    assign h_wd = clearing ? '0 : pick_sample(smp_raw);
    assign h_ra = base_row(wr_ptr, b) - step;

    assign c_we = clearing || (commit_en && (com_addr[LB-1:0] == LB'(b)));
    assign c_wa = clearing ? step : com_addr[TAP_AW-1 -: ROW_AW];
    assign c_wd = clearing ? '0 : com_data;

    fir_tm_ram #(.W(SAMP_W), .DEPTH(NSTEP)) u_hist (
      .clk (clk), .we (h_we), .wa (h_wa), .wd (h_wd), .ra (h_ra), .rd (hist_q[b])
    );

    fir_tm_ram #(.W(COEF_W), .DEPTH(NSTEP)) u_coef (
      .clk (clk), .we (c_we), .wa (c_wa), .wd (c_wd), .ra (step), .rd (coef_q[b])
    );

    fir_tm_lane #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .hv    (rd_v),
      .h     (hist_q[b]),
      .c     (coef_q[lane_of_bank(wr_ptr, b)]),
      .acc   (acc[b])
    );
  end

  // ---------------- combine and present ----------------
  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int b = 0; b < LANES; b++) total = total + widen_acc(acc[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= fin;
      if (fin) out_data <= scale_out(total);
      if (smp_evt && busy) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/fir_tm_engine_chk.sv
module fir_tm_engine_chk #(
  parameter int TAPS  = 2048,
  parameter int LANES = 4,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt,
  input logic             busy,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             overrun
);

  localparam int NSTEP = TAPS / LANES;

  // Counts edges since the accepting edge; the window length comes from a parameter.
  int unsigned lat;
  always_ff @(posedge clk) begin
    if (!rst_n)                lat <= 0;
    else if (evt && !busy)     lat <= 1;
    else if (out_valid)        lat <= 0;
    else if (lat != 0)         lat <= lat + 1;
  end

  // R5: the valid pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: the result appears a fixed number of cycles after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat == NSTEP + 4));

  // R5: an accepted sample makes the engine busy
  a_r5_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !busy) |=> busy);

  // R5: busy is low while the result is presented
  a_r5_idle_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);

  // R6: the output holds between pulses
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R7: an event while busy raises the overrun flag
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && busy) |=> overrun);

  // R7: the overrun flag is sticky
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind fir_tm_engine fir_tm_engine_chk #(
  .TAPS  (TAPS),
  .LANES (LANES),
  .OUT_W (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt       (smp_evt),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data),
  .overrun   (overrun)
);

// File: tb/fir_tm_engine_bench.sv
module fir_tm_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_TAPS    = 256;
  localparam int TB_LANES   = 4;
  localparam int NSTEP      = TB_TAPS / TB_LANES;
  localparam int AW         = $clog2(TB_TAPS);
  localparam int WATCHDOG   = 200000;

  // Stimulus vectors: raw 18-bit words; expected results come from the dot-product model.
  localparam logic [17:0] VEC [12] = '{
    18'h1FFFC, 18'h20000, 18'h00003, 18'h00404, 18'h3FFFC, 18'h12345,
    18'h2ABCD, 18'h0FFFF, 18'h30001, 18'h1C000, 18'h00010, 18'h25552
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            smp_tog = 1'b0;
  logic [17:0]     smp_raw = '0;
  logic            cw_en = 1'b0;
  logic [AW-1:0]   cw_addr = '0;
  logic [15:0]     cw_data = '0;
  logic [15:0]     out_data;
  logic            out_valid;
  logic            busy;
  logic            overrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_tm_engine #(.TAPS(TB_TAPS), .LANES(TB_LANES)) u_fir_tm_engine (
    .clk (clk), .rst_n (rst_n), .smp_tog (smp_tog), .smp_raw (smp_raw),
    .cw_en (cw_en), .cw_addr (cw_addr), .cw_data (cw_data),
    .out_data (out_data), .out_valid (out_valid), .busy (busy), .overrun (overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model: history shifts physically, newest at index 0.
  logic signed [15:0] hist_m [TB_TAPS];
  logic signed [15:0] coef_m [TB_TAPS];

  function automatic logic [15:0] model_out();
    longint     s = 0;
    logic [63:0] u;
    for (int k = 0; k < TB_TAPS; k++) s += longint'(coef_m[k]) * longint'(hist_m[k]);
    u = s;
    return u[35:20];
  endfunction

  function automatic void model_push(input logic [17:0] raw);
    for (int k = TB_TAPS - 1; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = raw[17:2];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_coef(input int k, input logic signed [15:0] v);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = AW'(k); cw_data = v;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  // mode 0: plain; 1: extra event while busy (R7); 2: coefficient writes while busy (R9)
  task automatic send(input logic [17:0] raw, input int mode);
    int cnt;
    @(negedge clk);
    smp_raw = raw;
    smp_tog = ~smp_tog;
    model_push(raw);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (mode == 1 && cnt == 10) begin smp_raw = 18'h0AAAA; smp_tog = ~smp_tog; end
      if (mode == 1 && cnt == 11) chk("R7 overrun raised", overrun, 1);
      if (mode == 2 && cnt == 5) begin cw_en = 1'b1; cw_addr = 0; cw_data = 16'sd12000; end
      if (mode == 2 && cnt == 6) begin cw_addr = 1; cw_data = -16'sd9000; end
      if (mode == 2 && cnt == 7) cw_en = 1'b0;
    end while (!out_valid && cnt < 3 * NSTEP);
    chk("R5 latency", cnt, NSTEP + 4);
    chk("R4 result", out_data, model_out());
    @(negedge clk);
    chk("R5 single pulse", out_valid, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int cnt;
    logic [15:0] held;
    bit extra;
    for (int k = 0; k < TB_TAPS; k++) begin hist_m[k] = 0; coef_m[k] = 0; end

    // R1: reset state and clearing window
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset out_data", out_data, 0);
    chk("R1 reset overrun", overrun, 0);
    chk("R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    cnt = 0;
    while (busy && cnt < 4 * NSTEP) begin @(negedge clk); cnt++; end
    chk("R1 clear window length", cnt, NSTEP);

    // R1: cleared coefficients give zero
    send(18'h1FFFC, 0);

    // R8: coefficients written while idle
    for (int k = 0; k < TB_TAPS; k++) begin
      logic signed [15:0] v;
      if (k == 0)      v = 16'sd271;
      else if (k == 1) v = -16'sd961;
      else if (k == 2) v = 16'sd2574;
      else             v = 16'(((k * 7919) % 4001 - 2000) * 8);
      wr_coef(k, v);
      coef_m[k] = v;
    end

    // R2, R3, R4: vector table, toggles alternate in direction
    for (int i = 0; i < 12; i++) send(VEC[i], 0);

    // R9: writes while busy; current result unchanged, only last write kept
    send(18'h1FFFC, 2);
    coef_m[1] = -16'sd9000;
    send(18'h10000, 0);

    // R6: output holds between pulses
    held = out_data;
    repeat (20) @(negedge clk);
    chk("R6 output hold", out_data, held);

    // R7: event while busy dropped, no extra pulse, flag sticky
    send(18'h04000, 1);
    extra = 0;
    repeat (2 * NSTEP) begin @(negedge clk); if (out_valid) extra = 1; end
    chk("R7 no extra result", extra, 0);
    send(18'h3F000, 0);
    chk("R7 overrun sticky", overrun, 1);

    // R10: run past the history length so the circular buffer wraps
    for (int i = 0; i < TB_TAPS + 20; i++) begin
      logic [31:0] r;
      r = 32'(i) * 32'd2654435761;
      send(r[17:0], 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule